// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

This block picks one warp per clock from a fixed pool of warp contexts and launches it into a shared lane pipeline. Because the pick rotates round-robin, consecutive cycles normally carry different warps. Each context keeps its own program counter, its own active-thread mask and a state of ready, waiting or done. The scheduler presents the chosen warp's ID, PC and mask on the issue port. The instruction store and decode outside the block look at that PC and report, in the same cycle, whether the instruction is an ordinary operation, a memory access or a halt.

A memory access raises a request tagged with the warp ID and parks the warp in the waiting set. Other ready warps keep issuing in the following cycles, so the warp's memory latency is hidden behind their work. A response carrying the warp ID returns the warp to ready. A halt retires the warp permanently. A summary flag reports when every warp has retired.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every warp is ready, with PC 0 and every lane bit of its mask set. With only ordinary operations, warps issue in the order 0, 1, 2, … and wrap around after the last warp.
- R2: At most one warp issues per cycle. `iss_valid` is high only when the warp on `iss_warp` is ready, and `iss_pc` and `iss_mask` show that warp's context.
- R3: The issued warp is the first ready warp found by scanning upward, with wrap-around, from the warp after the one issued last.
- R4: Each issue advances the issued warp's PC by exactly one. PCs of other warps do not change.
- R5: On issue, the warp's mask becomes its previous mask ANDed with `iss_keep`.
- R6: `iss_op` code 1 marks a memory access. In that cycle `mem_req_valid` is high and `mem_req_warp` equals `iss_warp`, and the warp enters the waiting set and is not selected.
- R7: A response (`mem_rsp_valid` with `mem_rsp_warp`) to a waiting warp makes it eligible from the next cycle on. A response naming a warp that is not waiting has no effect.
- R8: While one or more warps are waiting, the remaining ready warps keep issuing.
- R9: When no warp is ready, `iss_valid` is low for that cycle (a bubble).
- R10: `iss_op` code 2 is a halt. The warp becomes done and is never issued again, even if a response names it. Codes 0 and 3 are ordinary operations.
- R11: `all_done` is high exactly when every warp is done, and nothing issues then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | output | 1 | A warp issues this cycle |
| iss_warp | output | WID_W | ID of the issuing warp |
| iss_pc | output | PC_W | PC of the issuing warp |
| iss_mask | output | LANES | Active-thread mask of the issuing warp |
| iss_op | input | 2 | Class of the issued instruction: 0 ordinary, 1 memory, 2 halt, 3 ordinary |
| iss_keep | input | LANES | Lanes that stay active after the issued instruction |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_warp | output | WID_W | Warp that owns the request |
| mem_rsp_valid | input | 1 | Memory completion |
| mem_rsp_warp | input | WID_W | Warp whose access completed |
| all_done | output | 1 | Every warp has halted |

## Verification
The properties assume three things about the environment. `iss_op` is settled within the same cycle as the issue it describes, at most one completion arrives per cycle, and `mem_rsp_warp` names an existing warp. The stimulus drives the operation class from its own model of the expected warp. It returns completions one per cycle, with latencies that differ per warp and per phase. It also sends deliberate stray completions only to warps that are ready or done, never to a waiting warp whose access is still outstanding. The phases move from ordinary operations, to mixed memory traffic, to memory-only traffic that empties the ready set, and finally to halts.

// File: rtl/wis_pkg.sv
package wis_pkg;

    typedef enum logic [1:0] {
        WS_READY = 2'd0,
        WS_WAIT  = 2'd1,
        WS_DONE  = 2'd2
    } warp_state_e;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_MEM  = 2'd1,
        OP_HALT = 2'd2,
        OP_ALT  = 2'd3
    } issue_op_e;

    function automatic warp_state_e state_after_issue(input logic [1:0] op);
        case (issue_op_e'(op))
            OP_MEM:  return WS_WAIT;
            OP_HALT: return WS_DONE;
            default: return WS_READY;
        endcase
    endfunction

    function automatic logic op_is_mem(input logic [1:0] op);
        return issue_op_e'(op) == OP_MEM;
    endfunction

endpackage

// File: rtl/wis_warp_ctx.sv
module wis_warp_ctx
    import wis_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [1:0]       op,
    input  logic [LANES-1:0] keep,
    input  logic             wake,
    output logic             is_ready,
    output logic             is_wait,
    output logic             is_done,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] mask
);

    warp_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WS_READY;
            pc   <= '0;
            mask <= '1;
        end else if (issue) begin
            st_q <= state_after_issue(op);
            pc   <= pc + PC_W'(1);
            mask <= mask & keep;
        end else if (wake && st_q == WS_WAIT) begin
            st_q <= WS_READY;
        end
    end

    assign is_ready = (st_q == WS_READY);
    assign is_wait  = (st_q == WS_WAIT);
    assign is_done  = (st_q == WS_DONE);

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last) + i) % N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int LANES     = 32,
    parameter int PC_W      = 16,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             iss_valid,
    output logic [WID_W-1:0] iss_warp,
    output logic [PC_W-1:0]  iss_pc,
    output logic [LANES-1:0] iss_mask,
    input  logic [1:0]       iss_op,
    input  logic [LANES-1:0] iss_keep,
    output logic             mem_req_valid,
    output logic [WID_W-1:0] mem_req_warp,
    input  logic             mem_rsp_valid,
    input  logic [WID_W-1:0] mem_rsp_warp,
    output logic             all_done
);

    logic [NUM_WARPS-1:0] ready_vec;
    logic [NUM_WARPS-1:0] wait_vec;
    logic [NUM_WARPS-1:0] done_vec;
    logic [PC_W-1:0]      pc_arr   [NUM_WARPS];
    logic [LANES-1:0]     mask_arr [NUM_WARPS];
    logic [WID_W-1:0]     last_q;

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        wis_warp_ctx #(
            .PC_W (PC_W),
            .LANES(LANES)
        ) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .issue   (iss_valid && iss_warp == WID_W'(g)),
            .op      (iss_op),
            .keep    (iss_keep),
            .wake    (mem_rsp_valid && mem_rsp_warp == WID_W'(g)),
            .is_ready(ready_vec[g]),
            .is_wait (wait_vec[g]),
            .is_done (done_vec[g]),
            .pc      (pc_arr[g]),
            .mask    (mask_arr[g])
        );
    end

    wis_rr_pick #(
        .N    (NUM_WARPS),
        .IDX_W(WID_W)
    ) u_pick (
        .req      (ready_vec),
        .last     (last_q),
        .gnt_valid(iss_valid),
        .gnt_idx  (iss_warp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= WID_W'(NUM_WARPS - 1);
        end else if (iss_valid) begin
            last_q <= iss_warp;
        end
    end

    assign iss_pc        = pc_arr[iss_warp];
    assign iss_mask      = mask_arr[iss_warp];
    assign mem_req_valid = iss_valid && op_is_mem(iss_op);
    assign mem_req_warp  = iss_warp;
    assign all_done      = &done_vec;

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
    parameter int N     = 8,
    parameter int WID_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             iss_valid,
    input logic [WID_W-1:0] iss_warp,
    input logic [1:0]       iss_op,
    input logic             mem_rsp_valid,
    input logic [WID_W-1:0] mem_rsp_warp,
    input logic             all_done,
    input logic [N-1:0]     ready_vec,
    input logic [N-1:0]     wait_vec,
    input logic [N-1:0]     done_vec
);

    assert_issue_ready_R2: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> ready_vec[iss_warp]);

    assert_no_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (ready_vec != '0) |-> iss_valid);

    assert_mem_parks_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_op == 2'd1) |=> wait_vec[$past(iss_warp)]);

    assert_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && wait_vec[mem_rsp_warp]) |=> ready_vec[$past(mem_rsp_warp)]);

    assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_op == 2'd2) |=> done_vec[$past(iss_warp)]);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (done_vec != '0) |=> (($past(done_vec) & ~done_vec) == '0));

    assert_quiet_when_done_R11: assert property (@(posedge clk) disable iff (rst)
        all_done |-> !iss_valid);

endmodule

bind warp_issue_sched wis_checker #(
    .N    (NUM_WARPS),
    .WID_W(WID_W)
) u_wis_checker (
    .clk          (clk),
    .rst          (rst),
    .iss_valid    (iss_valid),
    .iss_warp     (iss_warp),
    .iss_op       (iss_op),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_warp (mem_rsp_warp),
    .all_done     (all_done),
    .ready_vec    (ready_vec),
    .wait_vec     (wait_vec),
    .done_vec     (done_vec)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;

    localparam int NW  = 8;
    localparam int LN  = 32;
    localparam int PCW = 16;
    localparam int WW  = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid;
    logic [WW-1:0] iss_warp;
    logic [PCW-1:0] iss_pc;
    logic [LN-1:0] iss_mask;
    logic [1:0]    iss_op;
    logic [LN-1:0] iss_keep;
    logic          mem_req_valid;
    logic [WW-1:0] mem_req_warp;
    logic          mem_rsp_valid;
    logic [WW-1:0] mem_rsp_warp;
    logic          all_done;

    always #2.5 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .LANES(LN), .PC_W(PCW)) i_warp_issue_sched (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_pc(iss_pc), .iss_mask(iss_mask),
        .iss_op(iss_op), .iss_keep(iss_keep),
        .mem_req_valid(mem_req_valid), .mem_req_warp(mem_req_warp),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_warp(mem_rsp_warp),
        .all_done(all_done)
    );

    // reference model: 0 ready, 1 waiting, 2 done
    int             st   [NW];
    logic [PCW-1:0] mpc  [NW];
    logic [LN-1:0]  mmask[NW];
    int             due  [NW];
    int             mlast;
    int errors = 0, checks = 0, overlap = 0, bubbles = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_pick();
        for (int i = 1; i <= NW; i++) begin
            int idx;
            idx = (mlast + i) % NW;
            if (st[idx] == 0) return idx;
        end
        return -1;
    endfunction

    initial begin
        #25000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        iss_op = 2'd0;
        iss_keep = '1;
        mem_rsp_valid = 1'b0;
        mem_rsp_warp = '0;
        for (int w = 0; w < NW; w++) begin
            st[w] = 0; mpc[w] = '0; mmask[w] = '1; due[w] = -1;
        end
        mlast = NW - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 valid", 64'(iss_valid), 64'd1);
        chk("R1 warp", 64'(iss_warp), 64'd0);
        chk("R1 pc", 64'(iss_pc), 64'd0);
        chk("R1 mask", 64'(iss_mask), 64'(32'hFFFF_FFFF));
        chk("R11 all_done after reset", 64'(all_done), 64'd0);

        for (int cyc = 0; cyc < 420; cyc++) begin
            int ew, op, rw, lat;
            bit rv, anyw, alld;
            logic [LN-1:0] kp;
            ew = model_pick();
            anyw = 0; alld = 1;
            for (int w = 0; w < NW; w++) begin
                if (st[w] == 1) anyw = 1;
                if (st[w] != 2) alld = 0;
            end
            chk("R2/R9 iss_valid", 64'(iss_valid), 64'(ew >= 0));
            chk("R11 all_done", 64'(all_done), 64'(alld));
            op = 0; kp = '1;
            if (ew >= 0) begin
                chk("R3/R7/R8/R10 iss_warp", 64'(iss_warp), 64'(ew));
                chk("R4 iss_pc", 64'(iss_pc), 64'(mpc[ew]));
                chk("R5 iss_mask", 64'(iss_mask), 64'(mmask[ew]));
                if (anyw) overlap++;
                if (cyc < 16) op = 0;
                else if (cyc < 200) op = (mpc[ew] % 3 == 2) ? 1 : ((mpc[ew] % 5 == 4) ? 3 : 0);
                else if (cyc < 300) op = 1;
                else op = 2;
                if (cyc >= 16 && mpc[ew] % 4 == 1)
                    kp = ~(32'h1 << ((ew + int'(mpc[ew])) % 32));
            end else begin
                bubbles++;
            end
            // completions: due ones first, otherwise an occasional stray one
            rv = 0; rw = 0;
            for (int w = 0; w < NW; w++) begin
                if (!rv && due[w] >= 0 && due[w] <= cyc) begin
                    rv = 1; rw = w;
                end
            end
            if (rv) due[rw] = -1;
            else if (cyc % 7 == 3 && st[(cyc / 7) % NW] != 1) begin
                rv = 1; rw = (cyc / 7) % NW;
            end
            iss_op = 2'(op);
            iss_keep = kp;
            mem_rsp_valid = rv;
            mem_rsp_warp = WW'(rw);
            #1;
            // R6: request raised in the issue cycle
            chk("R6 mem_req_valid", 64'(mem_req_valid), 64'(ew >= 0 && op == 1));
            if (ew >= 0 && op == 1) chk("R6 mem_req_warp", 64'(mem_req_warp), 64'(ew));
            @(posedge clk);
            // R7: response acts on pre-edge state; strays to non-waiting warps are ignored
            if (rv && st[rw] == 1) st[rw] = 0;
            if (ew >= 0) begin
                mpc[ew] = mpc[ew] + 1'b1;
                mmask[ew] = mmask[ew] & kp;
                mlast = ew;
                st[ew] = (op == 1) ? 1 : ((op == 2) ? 2 : 0);
                if (op == 1) begin
                    lat = (cyc < 200) ? (2 + (ew * 3) % 7) : (12 + ew);
                    due[ew] = cyc + lat;
                end
            end
            @(negedge clk);
        end

        chk("R8 issues while others wait", 64'(overlap > 0), 64'd1);
        chk("R9 bubbles seen", 64'(bubbles > 0), 64'd1);
        chk("R10/R11 all warps halted", 64'(all_done), 64'd1);
        chk("R11 no issue when all done", 64'(iss_valid), 64'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule